// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits next to a processor core and arbitrates among 256 numbered interrupt vectors. A higher vector number means a higher priority, and the upper four bits of a vector number form its priority class. Requesters pulse a set strobe with a vector number and a trigger mode. The block records the request as pending, and keeps a trigger-mode bit for each vector. It raises an interrupt line to the core when the best pending vector's class beats the current processor priority.

The core takes an interrupt with a one-cycle acknowledge strobe. The block answers on the next cycle with either the winning vector, which moves from pending to in-service, or a spurious vector when the task priority holds the request back. An end-of-interrupt strobe retires the highest in-service vector. A small indexed register port lets the core set the task priority and the enable/spurious register, and read the processor priority and all three bit vectors word by word.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset the pending, in-service and trigger vectors are all zero, the task priority is zero, the spurious register reads 0x0FF (enable bit 8 clear), the interrupt line is low and no acknowledge response is flagged.
- R2: A request strobe sets the pending bit of its vector; it sets that vector's trigger bit when the level flag is 1 and clears it when the flag is 0. Vector v lives in bit v mod 32 of status word v div 32.
- R3: The interrupt line is high exactly when bit 8 of the spurious register is set, some vector is pending, and either the processor priority is zero or the highest pending vector's class (bits 7:4) is greater than the processor priority's class.
- R4: The processor priority equals the task priority when nothing is in service or the task priority's class is at least the class of the highest in-service vector; otherwise it is that in-service class with a zero low nibble. It reads at register index 1.
- R5: One cycle after an acknowledge strobe, the response flag is high and the response vector is the low 8 bits of the spurious register if nothing is pending, or if the task priority is nonzero and the highest pending vector is not above it; otherwise it is the highest pending vector, which in that same step leaves pending and enters in-service.
- R6: End-of-interrupt clears the highest set in-service bit and only that bit; with nothing in service it changes nothing.
- R7: A write to register index 0 stores bits 3:0 of the write data as the task priority's class (low nibble zero); reading index 0 returns that 4-bit class.
- R8: A write to register index 2 keeps only bits 8:0 of the write data; reading index 2 returns them.
- R9: Among several pending vectors, acknowledges return them in descending vector order, and end-of-interrupt retires in-service vectors in descending order.
- R10: Register indices 8 to 15, 16 to 23 and 24 to 31 read pending, in-service and trigger words 0 to 7; writes to them, and to index 1, have no effect.
- R11: A request for the very vector being acknowledged in the same cycle leaves that vector both pending and in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request set strobe |
| req_vector | input | 8 | Vector number of the request |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | Acknowledge strobe from the core |
| ack_valid | output | 1 | Acknowledge response present |
| ack_vector | output | 8 | Vector returned to the core |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_out | output | 1 | Interrupt line to the core |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 5 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx (combinational) |

## Verification
Every strobe is taken at one rising edge, so the bit vectors, the interrupt line, the processor priority and the register read data all reflect it right after that edge, and the acknowledge response appears on the same edge. The bench drives each strobe for one cycle from the falling edge, then checks at the following falling edge, when exactly one register stage has passed. Read data is combinational on the index and is sampled a fraction of a cycle after the index changes, while no strobe is active. The sweeps cover all 256 vectors through the full request, acknowledge and retire path, and all sixteen task-priority classes against a fixed pending vector.

// File: rtl/vpc_pkg.sv
// Shared definitions for the vectored interrupt priority controller.
// Assumes the register index is {group, word}, the group in the top two bits.
package vpc_pkg;
    typedef enum logic [1:0] {
        GRP_CTRL = 2'd0,
        GRP_PEND = 2'd1,
        GRP_SERV = 2'd2,
        GRP_TRIG = 2'd3
    } reg_grp_e;

    localparam logic [2:0] CTRL_TASK_PRI = 3'd0;
    localparam logic [2:0] CTRL_PROC_PRI = 3'd1;
    localparam logic [2:0] CTRL_SPUR     = 3'd2;

    localparam int CLS_W = 4;
endpackage

// File: rtl/vpc_word_msb.sv
// Finds the highest set bit in one word.
// Assumes W is a power of two; pos is zero when found is low.
module vpc_word_msb #(
    parameter int W = 32,
    localparam int POS_W = $clog2(W)
) (
    input  logic [W-1:0]     bits,
    output logic             found,
    output logic [POS_W-1:0] pos
);
    // Scan upward so the last set bit seen is the highest one.
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                pos   = POS_W'(i);
            end
        end
    end
endmodule

// File: rtl/vpc_vec_search.sv
// Highest-set-bit search over a full vector, built as per-word finders
// followed by a pick of the highest non-empty word. Purely combinational.
// Assumes WORD_W divides 2**VEC_W.
module vpc_vec_search #(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 32,
    localparam int NV    = 1 << VEC_W,
    localparam int NW    = NV / WORD_W,
    localparam int POS_W = $clog2(WORD_W)
) (
    input  logic [NV-1:0]    vec,
    output logic             any,
    output logic [VEC_W-1:0] top
);
    logic [NW-1:0]    word_found;
    logic [POS_W-1:0] word_pos [NW];

    for (genvar w = 0; w < NW; w++) begin : g_word
        vpc_word_msb #(.W(WORD_W)) u_msb (
            .bits  (vec[w*WORD_W +: WORD_W]),
            .found (word_found[w]),
            .pos   (word_pos[w])
        );
    end

    // Pick the highest word with a set bit and join its number to the bit position.
    always_comb begin
        any = 1'b0;
        top = '0;
        for (int w = 0; w < NW; w++) begin
            if (word_found[w]) begin
                any = 1'b1;
                top = VEC_W'(w * WORD_W) | VEC_W'(word_pos[w]);
            end
        end
    end
endmodule

// File: rtl/vec_prio_ctrl.sv
// Vectored interrupt priority controller.
// Holds pending, in-service and trigger-mode bits per vector, derives the
// processor priority, drives the interrupt line, answers acknowledges one
// cycle later and retires in-service vectors on end-of-interrupt.
// Assumes at most one request, one acknowledge and one EOI per cycle;
// a same-cycle request wins over the acknowledge clearing the same vector.
module vec_prio_ctrl
    import vpc_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2 + $clog2((1 << VEC_W) / WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic              req_level,
    input  logic              ack_req,
    output logic              ack_valid,
    output logic [VEC_W-1:0]  ack_vector,
    input  logic              eoi,
    output logic              irq_out,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int NV     = 1 << VEC_W;
    localparam int WSEL_W = IDX_W - 2;
    localparam int LOW_W  = VEC_W - CLS_W;

    logic [NV-1:0]    pend_q, serv_q, trig_q;
    logic [VEC_W-1:0] tpr_q;
    logic [VEC_W:0]   spur_q;

    logic             pend_any, serv_any;
    logic [VEC_W-1:0] pend_top, serv_top;
    logic [VEC_W-1:0] ppr;
    logic             ack_spurious;
    logic [NV-1:0]    set_mask, take_mask, retire_mask;

    reg_grp_e          grp;
    logic [WSEL_W-1:0] wsel;
    assign grp  = reg_grp_e'(reg_idx[IDX_W-1 -: 2]);
    assign wsel = reg_idx[WSEL_W-1:0];

    vpc_vec_search #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_pend_search (
        .vec (pend_q), .any (pend_any), .top (pend_top)
    );

    vpc_vec_search #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_serv_search (
        .vec (serv_q), .any (serv_any), .top (serv_top)
    );

    // Processor priority: task priority unless a higher in-service class dominates.
    always_comb begin
        if (!serv_any || tpr_q[VEC_W-1 -: CLS_W] >= serv_top[VEC_W-1 -: CLS_W])
            ppr = tpr_q;
        else
            ppr = {serv_top[VEC_W-1 -: CLS_W], {LOW_W{1'b0}}};
    end

    // Interrupt line: enabled, something pending, and its class beats the processor class.
    assign irq_out = spur_q[VEC_W] && pend_any &&
                     ((ppr == '0) || (pend_top[VEC_W-1 -: CLS_W] > ppr[VEC_W-1 -: CLS_W]));

    // Acknowledge outcome and the per-cycle set/clear masks.
    always_comb begin
        ack_spurious = !pend_any || ((tpr_q != '0) && (pend_top <= tpr_q));
        set_mask     = req_valid ? (NV'(1) << req_vector) : '0;
        take_mask    = (ack_req && !ack_spurious) ? (NV'(1) << pend_top) : '0;
        retire_mask  = (eoi && serv_any) ? (NV'(1) << serv_top) : '0;
    end

    // Bit-vector state: requests, acknowledge moves and retirements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            serv_q <= '0;
            trig_q <= '0;
        end else begin
            pend_q <= (pend_q & ~take_mask) | set_mask;
            serv_q <= (serv_q & ~retire_mask) | take_mask;
            if (req_valid)
                trig_q[req_vector] <= req_level;
        end
    end

    // Acknowledge response register, valid one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid  <= 1'b0;
            ack_vector <= '0;
        end else begin
            ack_valid <= ack_req;
            if (ack_req)
                ack_vector <= ack_spurious ? spur_q[VEC_W-1:0] : pend_top;
        end
    end

    // Writable control registers: task priority and enable/spurious.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q  <= '0;
            spur_q <= {1'b0, {VEC_W{1'b1}}};
        end else if (reg_wr && grp == GRP_CTRL) begin
            if (wsel == WSEL_W'(CTRL_TASK_PRI))
                tpr_q <= {reg_wdata[CLS_W-1:0], {LOW_W{1'b0}}};
            else if (wsel == WSEL_W'(CTRL_SPUR))
                spur_q <= reg_wdata[VEC_W:0];
        end
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        unique case (grp)
            GRP_CTRL: begin
                if (wsel == WSEL_W'(CTRL_TASK_PRI))
                    reg_rdata = DATA_W'(tpr_q[VEC_W-1 -: CLS_W]);
                else if (wsel == WSEL_W'(CTRL_PROC_PRI))
                    reg_rdata = DATA_W'(ppr);
                else if (wsel == WSEL_W'(CTRL_SPUR))
                    reg_rdata = DATA_W'(spur_q);
            end
            GRP_PEND: reg_rdata = DATA_W'(pend_q[wsel*WORD_W +: WORD_W]);
            GRP_SERV: reg_rdata = DATA_W'(serv_q[wsel*WORD_W +: WORD_W]);
            GRP_TRIG: reg_rdata = DATA_W'(trig_q[wsel*WORD_W +: WORD_W]);
            default:  reg_rdata = '0;
        endcase
    end

    // R2
    req_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> pend_q[$past(req_vector)]);

    // R3
    irq_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && spur_q[VEC_W] && ppr == '0 && !ack_req && !eoi && !reg_wr) |=> irq_out);

    // R4
    ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= tpr_q);

    // R5
    ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> ack_valid);

    // R5
    ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_req |=> !ack_valid);

    // R6
    eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && serv_any && !ack_req) |=> $countones(serv_q) == $past($countones(serv_q)) - 1);

    // R6
    eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !serv_any && !ack_req) |=> serv_q == '0);

    // R9
    pend_top_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_any |-> ((pend_q >> pend_top) == NV'(1)));
endmodule

// File: tb/vec_prio_ctrl_test.sv
`timescale 1ns/1ps
module vec_prio_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic        req_level = 1'b0;
    logic        ack_req = 1'b0;
    logic        ack_valid;
    logic [7:0]  ack_vector;
    logic        eoi = 1'b0;
    logic        irq_out;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int failures = 0;

    vec_prio_ctrl uut (
        .clk, .rst_n, .req_valid, .req_vector, .req_level,
        .ack_req, .ack_valid, .ack_vector, .eoi, .irq_out,
        .reg_wr, .reg_idx, .reg_wdata, .reg_rdata
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] idx, output logic [31:0] d);
        reg_idx = idx;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] v, input logic lvl);
        @(negedge clk);
        req_valid = 1'b1; req_vector = v; req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic take(output logic [7:0] v);
        @(negedge clk);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        v = ack_vector;
    endtask

    task automatic retire();
        @(negedge clk);
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    function automatic logic [4:0] pidx(input logic [7:0] v); return {2'b01, v[7:5]}; endfunction
    function automatic logic [4:0] sidx(input logic [7:0] v); return {2'b10, v[7:5]}; endfunction
    function automatic logic [4:0] tidx(input logic [7:0] v); return {2'b11, v[7:5]}; endfunction

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", {31'b0, irq_out}, 32'd0);
        chk("R1 ack_valid", {31'b0, ack_valid}, 32'd0);
        for (int i = 8; i < 32; i++) begin
            rd(5'(i), d);
            chk("R1 status word", d, 32'd0);
        end
        rd(5'd0, d); chk("R1 task priority", d, 32'd0);
        rd(5'd2, d); chk("R1 spurious", d, 32'h0FF);

        // R8: only bits 8:0 kept
        wr(5'd2, 32'hFFFF_F1AB);
        rd(5'd2, d); chk("R8 spurious mask", d, 32'h1AB);
        wr(5'd2, 32'h0000_01F0);

        // R2 R3 R4 R5 R6: every vector through the full path
        for (int v = 0; v < 256; v++) begin
            logic [7:0] vb;
            vb = 8'(v);
            send(vb, vb[0]);
            rd(pidx(vb), d); chk("R2 pending bit", d, 32'd1 << vb[4:0]);
            rd(tidx(vb), d); chk("R2 trigger bit", {31'b0, d[vb[4:0]]}, {31'b0, vb[0]});
            chk("R3 irq on pending", {31'b0, irq_out}, 32'd1);
            take(got);
            chk("R5 ack vector", {24'b0, got}, {24'b0, vb});
            rd(pidx(vb), d); chk("R5 pending cleared", d, 32'd0);
            rd(sidx(vb), d); chk("R5 in-service set", d, 32'd1 << vb[4:0]);
            rd(5'd1, d);     chk("R4 ppr from isr", d, {24'b0, vb & 8'hF0});
            retire();
            rd(sidx(vb), d); chk("R6 eoi clears", d, 32'd0);
        end

        // R9: descending order
        send(8'h35, 1'b0); send(8'h90, 1'b0); send(8'h4A, 1'b1);
        take(got); chk("R9 first", {24'b0, got}, 32'h90);
        take(got); chk("R9 second", {24'b0, got}, 32'h4A);
        take(got); chk("R9 third", {24'b0, got}, 32'h35);
        retire();
        rd(sidx(8'h90), d); chk("R9 eoi top gone", d, 32'd0);
        rd(sidx(8'h4A), d); chk("R6 eoi only one", d, 32'd1 << 10);
        retire(); retire();
        rd(sidx(8'h35), d); chk("R9 all retired", d, 32'd0);

        // R3 R4: class masking by in-service vector
        send(8'h55, 1'b0); take(got);
        send(8'h52, 1'b0);
        chk("R3 same class masked", {31'b0, irq_out}, 32'd0);
        rd(5'd0, d);
        wr(5'd0, 32'd3); rd(5'd1, d); chk("R4 isr class dominates", d, 32'h50);
        wr(5'd0, 32'd8); rd(5'd1, d); chk("R4 tpr dominates", d, 32'h80);
        wr(5'd0, 32'd0);
        send(8'h61, 1'b0);
        chk("R3 higher class raises", {31'b0, irq_out}, 32'd1);
        take(got); chk("R5 class winner", {24'b0, got}, 32'h61);
        retire(); retire();
        retire();
        for (int w = 0; w < 8; w++) begin
            rd({2'b10, 3'(w)}, d); chk("R6 eoi on empty", d, 32'd0);
        end
        rd(5'd1, d); chk("R4 ppr zero", d, 32'd0);
        chk("R3 irq with ppr zero", {31'b0, irq_out}, 32'd1);
        take(got); chk("R5 masked one later", {24'b0, got}, 32'h52);
        retire();

        // R7 R3 R5: task priority sweep against vector 0x75
        for (int t = 0; t < 16; t++) begin
            logic [7:0] expv;
            wr(5'd0, 32'hFFFF_FFF0 | 32'(t));
            rd(5'd0, d); chk("R7 tpr readback", d, 32'(t));
            rd(5'd1, d); chk("R4 ppr equals tpr", d, 32'(t) << 4);
            send(8'h75, 1'b0);
            chk("R3 irq vs tpr", {31'b0, irq_out}, {31'b0, (t == 0) || (7 > t)});
            expv = (t != 0 && 8'h75 <= 8'(t * 16)) ? 8'hF0 : 8'h75;
            take(got); chk("R5 ack vs tpr", {24'b0, got}, {24'b0, expv});
            if (got == 8'h75) retire();
        end
        rd(pidx(8'h75), d); chk("R5 spurious keeps pending", d, 32'd1 << 21);
        wr(5'd0, 32'd0);

        // R3: enable bit off holds the line low
        wr(5'd2, 32'h0F0);
        chk("R3 disabled", {31'b0, irq_out}, 32'd0);
        wr(5'd2, 32'h1F0);
        chk("R3 re-enabled", {31'b0, irq_out}, 32'd1);
        take(got); retire();

        // R5: acknowledge with nothing pending
        take(got); chk("R5 empty ack spurious", {24'b0, got}, 32'hF0);
        rd(sidx(8'hF0), d); chk("R5 empty ack no isr", d, 32'd0);

        // R10: status and ppr writes ignored
        send(8'h21, 1'b1);
        wr(5'd9, 32'd0);
        rd(5'd9, d); chk("R10 pending write ignored", d, 32'd2);
        wr(5'd25, 32'd0);
        rd(5'd25, d); chk("R10 trigger write ignored", {31'b0, d[1]}, 32'd1);
        wr(5'd1, 32'h55);
        rd(5'd1, d); chk("R10 ppr write ignored", d, 32'd0);
        take(got); retire();

        // R11: request and acknowledge of the same vector in one cycle
        send(8'h40, 1'b0);
        @(negedge clk);
        ack_req = 1'b1; req_valid = 1'b1; req_vector = 8'h40; req_level = 1'b0;
        @(negedge clk);
        ack_req = 1'b0; req_valid = 1'b0;
        chk("R11 ack vector", {24'b0, ack_vector}, 32'h40);
        rd(pidx(8'h40), d); chk("R11 still pending", d, 32'd1);
        rd(sidx(8'h40), d); chk("R11 in service", d, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule